// File: doc/BRIEF.md
# Serial DAC Command Interface

This block takes 16-bit command words arriving on a three-wire serial link (a bit clock, an active-low frame select and a data line) and maintains a 12-bit DAC holding register. Each word carries a 4-bit command code in its upper bits and a 12-bit value in its lower bits. Only the load-and-update code changes the holding register. Any other code is accepted and dropped.

The block runs entirely on a system clock. The serial clock, frame select and data line are registered on that clock. Falling serial-clock edges and rising frame-select edges are found by comparing successive samples.

A static mode pin picks one of two modes:
- **Stand-alone:** the word is committed on the sixteenth falling serial-clock edge of a frame.
- **Chain:** the block keeps shifting for as long as the frame is open. The bit leaving the top of the shift register appears on the serial output for a downstream device. Whatever word sits in the register is committed when frame select rises.

Top module: `sdac_cmd_if`

## Requirements
- R1: After reset the DAC value is 0, the serial output is 0, and the shift register and bit counter are cleared.
- R2: In stand-alone mode, a word whose bits 15..12 equal 4'b0001 loads bits 11..0 into the DAC value on the sixteenth falling serial-clock edge of the frame, before frame select rises. Bits arrive MSB first.
- R3: A committed word whose bits 15..12 are anything other than 4'b0001 leaves the DAC value unchanged, in either mode.
- R4: While frame select is high, serial-clock activity changes neither the shift register nor the DAC value.
- R5: In stand-alone mode, falling edges after the sixteenth are ignored until frame select goes high again.
- R6: In stand-alone mode, a frame that closes after fewer than sixteen edges has no effect, and the next frame counts from zero.
- R7: In chain mode, the word in the shift register when frame select rises is decoded and committed, however many edges the frame held. This means the last sixteen bits shifted in.
- R8: In chain mode, the DAC value does not change while the frame is open, even after sixteen or more edges.
- R9: In chain mode, the serial output shows bit 15 of the shift register, so a word shifts out MSB first behind the incoming bits.
- R10: In stand-alone mode, the serial output is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chain_mode | input | 1 | Static mode select: 1 = chain, 0 = stand-alone |
| ser_clk | input | 1 | Serial bit clock; data shifts on its falling edge |
| ser_frame_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data in, MSB first |
| ser_dout | output | 1 | Serial data out (bit 15 of the shift register in chain mode) |
| dac_value | output | 12 | DAC holding register |

## Verification
The bench checks the DAC value right after the sixteenth edge in stand-alone mode, before the frame closes. A design that commits on frame rise, or one edge early, shows the wrong value there. It also sends extra trailing bits and short aborted frames. A counter that does not saturate or does not reset would load a shifted word, or start the next frame out of step.

In chain mode, the bench sends frames longer than sixteen bits and follows the serial output bit by bit. A design that commits at sixteen edges, or taps the wrong bit, shows up at once. Finally, it toggles the serial clock with the frame closed and then replays the register through an empty chain frame. A design that shifts while deselected would then reload a corrupted value.

// File: rtl/sdac_pkg.sv
// Shared constants for the serial DAC command interface.
// Assumes the command field sits in the top bits of the word.
package sdac_pkg;
    localparam int WORD_W  = 16;
    localparam int CMD_W   = 4;
    localparam int DATA_W  = WORD_W - CMD_W;
    localparam int CNT_W   = $clog2(WORD_W + 1);
    localparam logic [CMD_W-1:0] CMD_LOAD = 4'b0001;
endpackage

// File: rtl/sdac_sampler.sv
// Registers the serial inputs on the system clock and produces single-cycle
// pulses for serial-clock falling edges and frame-select rising edges.
// Assumes the serial clock is much slower than the system clock.
module sdac_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_frame_n,
    input  logic ser_din,
    output logic frame_q,
    output logic din_q,
    output logic sclk_fall,
    output logic frame_rise
);
    logic sclk_q, sclk_p, frame_p;

    // Sample the serial inputs and keep one previous copy of clock and frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            sclk_p  <= 1'b0;
            frame_q <= 1'b1;
            frame_p <= 1'b1;
            din_q   <= 1'b0;
        end else begin
            sclk_q  <= ser_clk;
            sclk_p  <= sclk_q;
            frame_q <= ser_frame_n;
            frame_p <= frame_q;
            din_q   <= ser_din;
        end
    end

    // Edge pulses from successive samples.
    assign sclk_fall  = sclk_p & ~sclk_q;
    assign frame_rise = frame_q & ~frame_p;
endmodule

// File: rtl/sdac_shifter.sv
// Input shift register and bit counter.
// Stand-alone mode: commits on the 16th edge and saturates the counter there.
// Chain mode: shifts freely and commits on frame-select rise.
// Assumes chain_mode changes only while the frame is closed.
module sdac_shifter
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_mode,
    input  logic              frame_q,
    input  logic              frame_rise,
    input  logic              sclk_fall,
    input  logic              din_q,
    output logic [WORD_W-1:0] word,
    output logic              commit
);
    logic [CNT_W-1:0] cnt;
    logic             room;

    assign room = chain_mode || (cnt < CNT_W'(WORD_W));

    // Shift, count and raise the commit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word   <= '0;
            cnt    <= '0;
            commit <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (frame_q) begin
                cnt <= '0;
                if (frame_rise && chain_mode)
                    commit <= 1'b1;
            end else if (sclk_fall && room) begin
                word <= {word[WORD_W-2:0], din_q};
                if (!chain_mode) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(WORD_W - 1))
                        commit <= 1'b1;
                end
            end
        end
    end

    // R4
    frame_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_q |=> $stable(word));

    // R5
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain_mode && cnt == CNT_W'(WORD_W)) |=> $stable(word));

    // R2
    edge16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !chain_mode) |-> cnt == CNT_W'(WORD_W));

    // R8
    chain_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_mode && !frame_q) |-> !commit);
endmodule

// File: rtl/sdac_commit.sv
// Decodes the command field of a committed word and updates the DAC register.
// Only the load-and-update code has an effect.
module sdac_commit
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [WORD_W-1:0] word,
    output logic [DATA_W-1:0] dac_q
);
    logic is_load;
    assign is_load = (word[WORD_W-1 -: CMD_W] == CMD_LOAD);

    // Holding register update on a committed load word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dac_q <= '0;
        else if (commit && is_load)
            dac_q <= word[DATA_W-1:0];
    end

    // R3
    nonload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && word[WORD_W-1 -: CMD_W] != CMD_LOAD) |=> $stable(dac_q));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(dac_q));
endmodule

// File: rtl/sdac_cmd_if.sv
// Top of the serial DAC command interface: sampler, shifter and commit stage.
// Fully synchronous to clk; the serial lines are treated as slow data inputs.
module sdac_cmd_if
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_mode,
    input  logic              ser_clk,
    input  logic              ser_frame_n,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic [DATA_W-1:0] dac_value
);
    logic              frame_q, din_q, sclk_fall, frame_rise, commit;
    logic [WORD_W-1:0] word;

    sdac_sampler u_samp (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_frame_n(ser_frame_n),
        .ser_din(ser_din), .frame_q(frame_q), .din_q(din_q),
        .sclk_fall(sclk_fall), .frame_rise(frame_rise)
    );

    sdac_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .chain_mode(chain_mode), .frame_q(frame_q),
        .frame_rise(frame_rise), .sclk_fall(sclk_fall), .din_q(din_q),
        .word(word), .commit(commit)
    );

    sdac_commit u_commit (
        .clk(clk), .rst_n(rst_n), .commit(commit), .word(word), .dac_q(dac_value)
    );

    // Pass the top bit downstream only in chain mode.
    assign ser_dout = chain_mode ? word[WORD_W-1] : 1'b0;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (dac_value == '0 && word == '0));
endmodule

// File: tb/sdac_cmd_if_test.sv
module sdac_cmd_if_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chain_mode = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_frame_n = 1'b1;
    logic        ser_din = 1'b0;
    logic        ser_dout;
    logic [11:0] dac_value;

    int total = 0;
    int bad = 0;

    sdac_cmd_if uut (
        .clk(clk), .rst_n(rst_n), .chain_mode(chain_mode), .ser_clk(ser_clk),
        .ser_frame_n(ser_frame_n), .ser_din(ser_din), .ser_dout(ser_dout),
        .dac_value(dac_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_din = b;
        ser_clk = 1'b1;
        tick(4);
        ser_clk = 1'b0;
        tick(4);
    endtask

    task automatic send_bits(input logic [15:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic open_frame;
        ser_frame_n = 1'b0;
        tick(4);
    endtask

    task automatic close_frame;
        ser_frame_n = 1'b1;
        tick(6);
    endtask

    task automatic t_reset;
        chk("R1 dac", {4'h0, dac_value}, 16'h0000);
        chk("R1 dout", {15'h0, ser_dout}, 16'h0000);
    endtask

    task automatic t_standalone_load;
        chain_mode = 1'b0;
        tick(2);
        open_frame();
        send_bits(16'h1A5C, 16);
        chk("R2 load before frame close", {4'h0, dac_value}, 16'h0A5C);
        close_frame();
        chk("R2 load after close", {4'h0, dac_value}, 16'h0A5C);
    endtask

    task automatic t_nonload;
        open_frame(); send_bits(16'h2FFF, 16); close_frame();
        chk("R3 code 2", {4'h0, dac_value}, 16'h0A5C);
        open_frame(); send_bits(16'h0FFF, 16); close_frame();
        chk("R3 code 0", {4'h0, dac_value}, 16'h0A5C);
        open_frame(); send_bits(16'hF000, 16);
        chk("R10 dout standalone", {15'h0, ser_dout}, 16'h0000);
        close_frame();
        chk("R3 code F", {4'h0, dac_value}, 16'h0A5C);
    endtask

    task automatic t_extra_edges;
        open_frame();
        send_bits(16'h1456, 16);
        chk("R2 second load", {4'h0, dac_value}, 16'h0456);
        send_bits(16'h000F, 4);
        close_frame();
        chk("R5 trailing edges ignored", {4'h0, dac_value}, 16'h0456);
    endtask

    task automatic t_abort;
        open_frame();
        send_bits(16'h1FFF, 10);
        close_frame();
        chk("R6 short frame", {4'h0, dac_value}, 16'h0456);
        open_frame(); send_bits(16'h1777, 16); close_frame();
        chk("R6 next frame aligned", {4'h0, dac_value}, 16'h0777);
    endtask

    task automatic t_chain_long;
        chain_mode = 1'b1;
        tick(2);
        open_frame();
        send_bits(16'h000A, 4);
        send_bits(16'h1321, 16);
        chk("R8 no commit while open", {4'h0, dac_value}, 16'h0777);
        close_frame();
        chk("R7 commit on frame rise", {4'h0, dac_value}, 16'h0321);
    endtask

    task automatic t_chain_dout;
        logic [15:0] w;
        w = 16'hA123;
        open_frame();
        send_bits(w, 16);
        chk("R9 dout bit15", {15'h0, ser_dout}, {15'h0, w[15]});
        for (int k = 1; k <= 3; k++) begin
            send_bit(1'b0);
            chk("R9 dout follows", {15'h0, ser_dout}, {15'h0, w[15-k]});
        end
        close_frame();
        chk("R3 chain non-load", {4'h0, dac_value}, 16'h0321);
    endtask

    task automatic t_idle_clock;
        chain_mode = 1'b0;
        tick(2);
        open_frame(); send_bits(16'h1123, 16); close_frame();
        chk("R2 setup load", {4'h0, dac_value}, 16'h0123);
        chain_mode = 1'b1;
        tick(2);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        chk("R4 dac while idle", {4'h0, dac_value}, 16'h0123);
        chk("R4 dout while idle", {15'h0, ser_dout}, 16'h0000);
        open_frame();
        close_frame();
        chk("R4 register kept", {4'h0, dac_value}, 16'h0123);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_standalone_load();
        t_nonload();
        t_extra_edges();
        t_abort();
        t_chain_long();
        t_chain_dout();
        t_idle_clock();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule